// File: doc/BRIEF.md
# Dual Signal Notification Registers

This block holds two 32-bit notification words for one processing element. Remote agents, such as the control processor or a peer element, post a word with a single 4-byte store. The store reaches the block as a one-cycle write strobe with a register select and the data. The local core takes a word through a channel-style read. The read returns the stored word and empties the register.

Each register has its own accumulation mode. In overwrite mode a posted word replaces whatever is held. In OR mode the posted word is merged bitwise into the held value, so bits set by earlier posts are kept until the core reads them. A one-bit count per register tells the core whether a word is waiting. A mode configuration strobe loads both mode bits at once.

Top module: `sig_notify_regs`

## Requirements
- R1: After reset, both registers hold zero, both counts are 0, and both modes are overwrite.
- R2: In overwrite mode (mode bit 0), a write to a register makes it hold exactly the written word on the next cycle, and its count becomes 1. This holds even when the word is zero.
- R3: In OR mode (mode bit 1), a write with no read in the same cycle leaves the register holding the old value ORed with the written word.
- R4: A cycle with `cfg_we` high loads `cfg_mode`, where bit i is the mode of register i. A write in that same cycle still uses the previous mode. Each register follows only its own mode bit.
- R5: `rd_data` slice i always shows register i. When `rd_req[i]` is high and the count is 1, `rd_ack[i]` is high in that cycle, and on the next cycle the register is zero and its count is 0.
- R6: When `rd_req[i]` is high and the count is 0, `rd_ack[i]` stays low and the register is left unchanged.
- R7: When an acknowledged read and a write hit the same register in the same cycle, the read returns the old value. The register then holds only the new word, whatever the mode.
- R8: In OR mode, a write of all zeros does not raise a count that is 0.
- R9: `wr_sel` value i addresses register i. A write never alters the other register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Remote write strobe |
| wr_sel | input | 1 | Target register of the write |
| wr_data | input | 32 | Written word |
| cfg_we | input | 1 | Mode load strobe |
| cfg_mode | input | 2 | Mode bits, 1 = OR, 0 = overwrite |
| rd_req | input | 2 | Local read request per register |
| rd_ack | output | 2 | Read accepted (data valid) per register |
| rd_data | output | 64 | Register values, register i at bits 32*i+31:32*i |
| sig_count | output | 2 | Pending count per register |

## Verification
A wrong held value appears on `rd_data` on the cycle after the faulty update, because the register drives the port directly. A wrong pending bit appears at once on `sig_count`, and on `rd_ack` at the next read. A wrong mode bit stays hidden until the next write to that register: that write then either replaces bits that should have stayed or keeps bits that should have gone. For this reason the bench follows every mode change with a write to each register.

// File: rtl/sig_pkg.sv
package sig_pkg;
  localparam int unsigned SIG_W = 32;
  typedef enum logic { MODE_OVERWRITE = 1'b0, MODE_OR = 1'b1 } sig_mode_e;

  // Value the register takes after a write; base is zero if a read drained it.
  function automatic logic [SIG_W-1:0] sig_merge(input logic mode_or,
                                                 input logic [SIG_W-1:0] base,
                                                 input logic [SIG_W-1:0] data);
    return mode_or ? (base | data) : data;
  endfunction

  // Pending flag after a write; OR mode keeps the base flag unless data is non-zero.
  function automatic logic sig_pend_next(input logic mode_or,
                                         input logic base_pend,
                                         input logic [SIG_W-1:0] data);
    return mode_or ? (base_pend || (data != '0)) : 1'b1;
  endfunction
endpackage

// File: rtl/sig_mode_reg.sv
module sig_mode_reg #(
  parameter int unsigned NUM = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_we,
  input  logic [NUM-1:0] cfg_mode,
  output logic [NUM-1:0] mode_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)      mode_q <= '0;
    else if (cfg_we) mode_q <= cfg_mode;
  end

  a_r4_mode_load: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n && cfg_we |=> mode_q == $past(cfg_mode));
  a_r4_mode_hold: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n && !cfg_we |=> $stable(mode_q));
endmodule

// File: rtl/sig_slot.sv
module sig_slot
  import sig_pkg::*;
#(
  parameter int unsigned W = SIG_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         mode_or,
  input  logic         wr_hit,
  input  logic [W-1:0] wr_data,
  input  logic         rd_req,
  output logic         rd_ack,
  output logic [W-1:0] value_q,
  output logic         pend_q
);
  logic         rd_hit;
  logic [W-1:0] base_val;
  logic         base_pend;
  logic [W-1:0] value_d;
  logic         pend_d;

  assign rd_hit    = rd_req && pend_q;
  assign rd_ack    = rd_hit;
  assign base_val  = rd_hit ? '0 : value_q;
  assign base_pend = rd_hit ? 1'b0 : pend_q;

  always_comb begin
    value_d = value_q;
    pend_d  = pend_q;
    if (wr_hit) begin
      value_d = sig_merge(mode_or, base_val, wr_data);
      pend_d  = sig_pend_next(mode_or, base_pend, wr_data);
    end else if (rd_hit) begin
      value_d = '0;
      pend_d  = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      value_q <= '0;
      pend_q  <= 1'b0;
    end else begin
      value_q <= value_d;
      pend_q  <= pend_d;
    end
  end

  a_r2_overwrite: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n && wr_hit && !mode_or |=> value_q == $past(wr_data) && pend_q);
  a_r3_or_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n && wr_hit && mode_or && !rd_hit |=> value_q == ($past(value_q) | $past(wr_data)));
  a_r5_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n && rd_hit && !wr_hit |=> value_q == '0 && !pend_q);
  a_r6_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n && !wr_hit && !rd_hit |=> $stable(value_q) && $stable(pend_q));
  a_r7_collision: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n && rd_hit && wr_hit |=> value_q == $past(wr_data));
  a_r8_or_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n && wr_hit && mode_or && wr_data == '0 && !pend_q |=> !pend_q);
endmodule

// File: rtl/sig_notify_regs.sv
module sig_notify_regs
  import sig_pkg::*;
#(
  parameter int unsigned NUM = 2,
  parameter int unsigned W   = SIG_W,
  localparam int unsigned SEL_W = (NUM > 1) ? $clog2(NUM) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_valid,
  input  logic [SEL_W-1:0] wr_sel,
  input  logic [W-1:0]     wr_data,
  input  logic             cfg_we,
  input  logic [NUM-1:0]   cfg_mode,
  input  logic [NUM-1:0]   rd_req,
  output logic [NUM-1:0]   rd_ack,
  output logic [NUM*W-1:0] rd_data,
  output logic [NUM-1:0]   sig_count
);
  logic [NUM-1:0] mode_q;
  logic [NUM-1:0] wr_hit;

  sig_mode_reg #(.NUM(NUM)) u_mode (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_mode(cfg_mode), .mode_q(mode_q)
  );

  for (genvar i = 0; i < NUM; i++) begin : g_slot
    assign wr_hit[i] = wr_valid && (wr_sel == SEL_W'(i));
    sig_slot #(.W(W)) u_slot (
      .clk(clk), .rst_n(rst_n), .mode_or(mode_q[i]), .wr_hit(wr_hit[i]),
      .wr_data(wr_data), .rd_req(rd_req[i]), .rd_ack(rd_ack[i]),
      .value_q(rd_data[i*W +: W]), .pend_q(sig_count[i])
    );
  end

  a_r9_single_target: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_hit));
endmodule

// File: tb/sig_notify_regs_tb.sv
`timescale 1ns/1ps
module sig_notify_regs_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_valid = 1'b0;
  logic [0:0]  wr_sel = '0;
  logic [31:0] wr_data = '0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_mode = '0;
  logic [1:0]  rd_req = '0;
  logic [1:0]  rd_ack;
  logic [63:0] rd_data;
  logic [1:0]  sig_count;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  sig_notify_regs u_dut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_sel(wr_sel), .wr_data(wr_data),
    .cfg_we(cfg_we), .cfg_mode(cfg_mode), .rd_req(rd_req), .rd_ack(rd_ack),
    .rd_data(rd_data), .sig_count(sig_count)
  );

  typedef struct packed {
    logic        wv;
    logic        ws;
    logic [31:0] wd;
    logic        cw;
    logic [1:0]  cm;
    logic [1:0]  rr;
    logic [1:0]  ack;
    logic [1:0]  cnt;
    logic [31:0] d0;
    logic [31:0] d1;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{1'b1,1'b0,32'h000000A5,1'b0,2'b00,2'b00,2'b00,2'b01,32'h000000A5,32'h0},        // R2, R9
    '{1'b1,1'b0,32'h00001200,1'b0,2'b00,2'b00,2'b00,2'b01,32'h00001200,32'h0},        // R2 replace
    '{1'b1,1'b1,32'h00000000,1'b0,2'b00,2'b00,2'b00,2'b11,32'h00001200,32'h0},        // R2 zero word
    '{1'b0,1'b0,32'h0,1'b0,2'b00,2'b01,2'b01,2'b10,32'h0,32'h0},                      // R5 read
    '{1'b0,1'b0,32'h0,1'b0,2'b00,2'b01,2'b00,2'b10,32'h0,32'h0},                      // R6 empty read
    '{1'b1,1'b0,32'h0000000F,1'b1,2'b01,2'b00,2'b00,2'b11,32'h0000000F,32'h0},        // R4 old mode
    '{1'b1,1'b0,32'h000000F0,1'b0,2'b00,2'b00,2'b00,2'b11,32'h000000FF,32'h0},        // R3 OR
    '{1'b1,1'b1,32'hAAAA0000,1'b0,2'b00,2'b00,2'b00,2'b11,32'h000000FF,32'hAAAA0000}, // R4 independent
    '{1'b1,1'b1,32'h00005555,1'b0,2'b00,2'b00,2'b00,2'b11,32'h000000FF,32'h00005555}, // R4 s1 overwrite
    '{1'b1,1'b0,32'h0,1'b0,2'b00,2'b01,2'b01,2'b10,32'h0,32'h00005555},               // R7, R8
    '{1'b1,1'b0,32'h0,1'b0,2'b00,2'b00,2'b00,2'b10,32'h0,32'h00005555},               // R8 zero OR
    '{1'b1,1'b0,32'h00000100,1'b0,2'b00,2'b01,2'b00,2'b11,32'h00000100,32'h00005555}, // R6 + R3
    '{1'b1,1'b0,32'h00000003,1'b0,2'b00,2'b01,2'b01,2'b11,32'h00000003,32'h00005555}, // R7 OR mode
    '{1'b0,1'b0,32'h0,1'b0,2'b00,2'b11,2'b11,2'b00,32'h0,32'h0},                      // R5 both
    '{1'b1,1'b1,32'h00000007,1'b1,2'b11,2'b00,2'b00,2'b10,32'h0,32'h00000007},        // R4 old mode s1
    '{1'b1,1'b1,32'h00000008,1'b0,2'b00,2'b00,2'b00,2'b10,32'h0,32'h0000000F}         // R3 s1 OR
  };
  localparam int VREQ [NV] = '{2,2,2,5,6,4,3,4,4,7,8,6,7,5,4,3};

  task automatic check(input int req, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic wv, input logic ws, input logic [31:0] wd,
                       input logic cw, input logic [1:0] cm, input logic [1:0] rr);
    @(negedge clk);
    wr_valid = wv; wr_sel = ws; wr_data = wd; cfg_we = cw; cfg_mode = cm; rd_req = rr;
  endtask

  task automatic idle();
    drive(1'b0, 1'b0, 32'h0, 1'b0, 2'b00, 2'b00);
  endtask

  initial begin
    logic [31:0] prev0, prev1;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1;
    check(1, "reset count", {62'h0, sig_count}, 64'h0);
    check(1, "reset data", rd_data, 64'h0);
    prev0 = 32'h0; prev1 = 32'h0;
    for (int k = 0; k < NV; k++) begin
      drive(VECS[k].wv, VECS[k].ws, VECS[k].wd, VECS[k].cw, VECS[k].cm, VECS[k].rr);
      #1;
      check(VREQ[k], $sformatf("vec %0d ack", k), {62'h0, rd_ack}, {62'h0, VECS[k].ack});
      check(VREQ[k], $sformatf("vec %0d read value", k), rd_data, {prev1, prev0});
      @(posedge clk); #1;
      check(VREQ[k], $sformatf("vec %0d count", k), {62'h0, sig_count}, {62'h0, VECS[k].cnt});
      check(VREQ[k], $sformatf("vec %0d data", k), rd_data, {VECS[k].d1, VECS[k].d0});
      prev0 = VECS[k].d0; prev1 = VECS[k].d1;
    end
    // R1: reset mid-run clears values, counts and modes (both OR before reset)
    drive(1'b1, 1'b0, 32'h00000030, 1'b1, 2'b11, 2'b00);
    @(negedge clk); rst_n = 1'b0; wr_valid = 1'b0; cfg_we = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    #1;
    check(1, "reset count mid-run", {62'h0, sig_count}, 64'h0);
    check(1, "reset data mid-run", rd_data, 64'h0);
    drive(1'b1, 1'b0, 32'h000000C0, 1'b0, 2'b00, 2'b00);
    drive(1'b1, 1'b0, 32'h00000003, 1'b0, 2'b00, 2'b00);
    drive(1'b1, 1'b1, 32'h00000011, 1'b0, 2'b00, 2'b00);
    drive(1'b1, 1'b1, 32'h00000022, 1'b0, 2'b00, 2'b00);
    idle();
    #1;
    check(1, "overwrite mode after reset s0", {32'h0, rd_data[31:0]}, 64'h3);
    check(1, "overwrite mode after reset s1", {32'h0, rd_data[63:32]}, 64'h22);
    // R6: empty register read leaves the other untouched and no ack
    drive(1'b0, 1'b0, 32'h0, 1'b0, 2'b00, 2'b11);
    #1;
    check(5, "ack both pending", {62'h0, rd_ack}, 64'h3);
    idle();
    drive(1'b0, 1'b0, 32'h0, 1'b0, 2'b00, 2'b11);
    #1;
    check(6, "no ack when empty", {62'h0, rd_ack}, 64'h0);
    idle();
    #1;
    check(6, "empty stays empty", {62'h0, sig_count}, 64'h0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      fails++;
      $display("FAIL R1 watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule